// File: doc/BRIEF.md
# Bus Error Status and Timeout Address Capture

This block holds the error status word of a backplane bus adapter together with a timeout address register. Single-cycle event strobes report errors from the bus side: timeouts, error confirmations, corrected-data and substituted-data errors, and the interface-buffer versions of these. The first timeout records the failing longword address. For a virtual access it also records the access mode. Any later timeout or confirmation that arrives while the matching flag is still set only raises a shared multiple-error flag.

Software reads the status word through a fixed visibility mask. It sets or clears the single interrupt-enable bit by writing it, and clears error flags by writing ones to them. Writing one to either timeout flag also clears a group of companion bits. A machine-check acknowledge strobe clears the main timeout group in the same way. A level output raises an interrupt request for corrected errors whenever both the enable and the corrected-error flag are set.

The register port is a plain one-cycle write strobe with a combinational read of the current word. It has no back-pressure, and every event and write strobe takes effect at the next clock edge.

Top module: `bus_err_capture`

## Requirements
- R1: While reset is low, and after it is released, the status read value `reg_rdata`, the timeout address `ta_rdata` and `crd_irq` are all zero.
- R2: `reg_rdata` always equals the stored word ANDed with 0x0000FDFE, so bits 31:16, 9 and 0 read zero. Bit 1 shows `bus_free` as sampled on the previous clock edge.
- R3: Bit 15 (corrected-error interrupt enable) takes the written value on each write. A write has no set effect on any other bit: writing all ones to a status word that holds zero yields 0x8000, apart from bit 1.
- R4: Writing one to bit 14 (corrected), bit 13 (substituted data) or bit 7 (buffer substituted data) clears that bit. Writing zero leaves it unchanged.
- R5: Writing one to bit 12 clears bits 12, 11:10, 8 and 2.
- R6: Writing one to bit 6 clears bits 6, 11:10 and 3, and leaves bits 5:4 unchanged.
- R7: A timeout event `tmo_evt` while bit 12 is clear does three things: it sets bit 12, loads bits 11:10 from `tmo_code`, and loads `ta_rdata` with `tmo_addr[31:2]` in bits 29:0 and zeros in bits 31:30.
- R8: If `tmo_virt` is high on a first timeout, the captured value also has bit 29 set and `tmo_mode` in bits 31:30.
- R9: A timeout event while bit 12 is set changes neither `ta_rdata` nor bits 11:10, and sets bit 2.
- R10: A confirmation event `cnf_evt` sets bit 8 if it is clear. If bit 8 is already set, it sets bit 2.
- R11: A buffer timeout `ib_tmo_evt` sets bit 6 and loads bits 5:4 from `ib_code` when bit 6 is clear, and otherwise sets bit 2. A buffer confirmation sets bit 3 when clear, and otherwise sets bit 2. A buffer substituted-data event sets bit 7.
- R12: `rds_evt` sets bit 13 and `crd_evt` sets bit 14. `crd_irq` is high exactly when bits 15 and 14 are both set.
- R13: `mchk_ack` clears bits 12, 11:10, 8 and 2.
- R14: When an event and a clearing write or `mchk_ack` fall in the same cycle, the clear is applied first and the event's set is applied after it. The first/multiple decision uses the cleared value, so a timeout that coincides with a bit-12 clear makes a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_evt | input | 1 | Bus timeout event strobe |
| tmo_addr | input | 32 | Physical byte address of the timed-out access |
| tmo_virt | input | 1 | Timed-out access used a virtual address |
| tmo_mode | input | 2 | Access mode of the timed-out access |
| tmo_code | input | 2 | Timeout status code stored in bits 11:10 |
| cnf_evt | input | 1 | Error confirmation event strobe |
| rds_evt | input | 1 | Substituted read data event strobe |
| crd_evt | input | 1 | Corrected read data event strobe |
| ib_tmo_evt | input | 1 | Interface-buffer timeout event strobe |
| ib_code | input | 2 | Interface-buffer timeout code stored in bits 5:4 |
| ib_cnf_evt | input | 1 | Interface-buffer confirmation event strobe |
| ib_rds_evt | input | 1 | Interface-buffer substituted data event strobe |
| bus_free | input | 1 | Bus idle indication mirrored into bit 1 |
| mchk_ack | input | 1 | Machine-check acknowledge, clears the timeout group |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Status register write data |
| reg_rdata | output | 32 | Masked status register read value |
| ta_rdata | output | 32 | Captured timeout address word |
| crd_irq | output | 1 | Corrected-error interrupt request |

## Verification
The collision to watch is between an error event and a clear of the same flag group. The clear can come from a software write-one or from the machine-check acknowledge. Each directed task drives the event strobe and the clearing strobe on the same clock edge. It then checks that the flag reads set afterwards. For a timeout whose bit-12 clear coincides with the event, it also checks that the address register holds the new address, not the old one.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam int unsigned SW = 32;

  localparam int unsigned B_CRDIE   = 15;
  localparam int unsigned B_CRD     = 14;
  localparam int unsigned B_RDS     = 13;
  localparam int unsigned B_TMO     = 12;
  localparam int unsigned B_STA_LO  = 10;
  localparam int unsigned B_CNF     = 8;
  localparam int unsigned B_IBRDS   = 7;
  localparam int unsigned B_IBTMO   = 6;
  localparam int unsigned B_IBSTA_LO = 4;
  localparam int unsigned B_IBCNF   = 3;
  localparam int unsigned B_MULT    = 2;
  localparam int unsigned B_FREE    = 1;

  localparam logic [SW-1:0] RD_MASK  = 32'h0000_FDFE;
  localparam logic [SW-1:0] WR_MASK  = 32'h0000_8000;
  localparam logic [SW-1:0] W1C_MASK = 32'h0000_70C0;
  localparam logic [SW-1:0] TMO_GRP  = 32'h0000_1D04;
  localparam logic [SW-1:0] IBT_GRP  = 32'h0000_0C48;

  localparam int unsigned TA_W     = 32;
  localparam int unsigned TA_VIRT  = 29;
  localparam int unsigned TA_MODE_LO = 30;

  typedef enum logic [1:0] {
    CH_TMO   = 2'd0,
    CH_CNF   = 2'd1,
    CH_IBTMO = 2'd2,
    CH_IBCNF = 2'd3
  } chan_e;
  localparam int unsigned NCH = 4;
endpackage

// File: rtl/bes_first_latch.sv
module bes_first_latch (
  input  logic evt,
  input  logic held,
  output logic first,
  output logic mult
);
  always_comb begin
    first = evt & ~held;
    mult  = evt &  held;
  end
endmodule

// File: rtl/bes_ta_capture.sv
module bes_ta_capture
  import bes_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [AW-1:0]   addr,
  input  logic            virt,
  input  logic [1:0]      mode,
  output logic [TA_W-1:0] ta_q
);
  logic [TA_W-1:0] ta_d;

  always_comb begin
    ta_d = TA_W'(addr >> 2);
    if (virt) begin
      ta_d[TA_VIRT] = 1'b1;
      ta_d[TA_MODE_LO +: 2] = mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ta_q <= '0;
    else if (capture) ta_q <= ta_d;
  end
endmodule

// File: rtl/bes_status_reg.sv
module bes_status_reg
  import bes_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [SW-1:0] wdata,
  input  logic          mchk_ack,
  input  logic          tmo_evt,
  input  logic [1:0]    tmo_code,
  input  logic          cnf_evt,
  input  logic          rds_evt,
  input  logic          crd_evt,
  input  logic          ib_tmo_evt,
  input  logic [1:0]    ib_code,
  input  logic          ib_cnf_evt,
  input  logic          ib_rds_evt,
  input  logic          bus_free,
  output logic [SW-1:0] st_q,
  output logic          tmo_first
);
  logic [SW-1:0]  cleared;
  logic [SW-1:0]  st_d;
  logic [NCH-1:0] evt_v;
  logic [NCH-1:0] held_v;
  logic [NCH-1:0] first_v;
  logic [NCH-1:0] mult_v;

  // software and acknowledge clears come first
  always_comb begin
    cleared = st_q;
    if (wr) begin
      cleared = (cleared & ~WR_MASK) | (wdata & WR_MASK);
      cleared = cleared & ~(wdata & W1C_MASK);
      if (wdata[B_TMO])   cleared = cleared & ~TMO_GRP;
      if (wdata[B_IBTMO]) cleared = cleared & ~IBT_GRP;
    end
    if (mchk_ack) cleared = cleared & ~TMO_GRP;
  end

  always_comb begin
    evt_v[CH_TMO]    = tmo_evt;
    evt_v[CH_CNF]    = cnf_evt;
    evt_v[CH_IBTMO]  = ib_tmo_evt;
    evt_v[CH_IBCNF]  = ib_cnf_evt;
    held_v[CH_TMO]   = cleared[B_TMO];
    held_v[CH_CNF]   = cleared[B_CNF];
    held_v[CH_IBTMO] = cleared[B_IBTMO];
    held_v[CH_IBCNF] = cleared[B_IBCNF];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    bes_first_latch u_fl (
      .evt   (evt_v[g]),
      .held  (held_v[g]),
      .first (first_v[g]),
      .mult  (mult_v[g])
    );
  end

  // events set on top of the cleared value
  always_comb begin
    st_d = cleared;
    st_d[B_FREE] = bus_free;
    if (first_v[CH_TMO]) begin
      st_d[B_TMO] = 1'b1;
      st_d[B_STA_LO +: 2] = tmo_code;
    end
    if (first_v[CH_CNF])   st_d[B_CNF] = 1'b1;
    if (first_v[CH_IBTMO]) begin
      st_d[B_IBTMO] = 1'b1;
      st_d[B_IBSTA_LO +: 2] = ib_code;
    end
    if (first_v[CH_IBCNF]) st_d[B_IBCNF] = 1'b1;
    if (|mult_v)           st_d[B_MULT]  = 1'b1;
    if (rds_evt)           st_d[B_RDS]   = 1'b1;
    if (crd_evt)           st_d[B_CRD]   = 1'b1;
    if (ib_rds_evt)        st_d[B_IBRDS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign tmo_first = first_v[CH_TMO];
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bes_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmo_evt,
  input  logic [AW-1:0] tmo_addr,
  input  logic          tmo_virt,
  input  logic [1:0]    tmo_mode,
  input  logic [1:0]    tmo_code,
  input  logic          cnf_evt,
  input  logic          rds_evt,
  input  logic          crd_evt,
  input  logic          ib_tmo_evt,
  input  logic [1:0]    ib_code,
  input  logic          ib_cnf_evt,
  input  logic          ib_rds_evt,
  input  logic          bus_free,
  input  logic          mchk_ack,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [31:0]   ta_rdata,
  output logic          crd_irq
);
  logic [SW-1:0] st;
  logic          tmo_first;

  bes_status_reg u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .mchk_ack   (mchk_ack),
    .tmo_evt    (tmo_evt),
    .tmo_code   (tmo_code),
    .cnf_evt    (cnf_evt),
    .rds_evt    (rds_evt),
    .crd_evt    (crd_evt),
    .ib_tmo_evt (ib_tmo_evt),
    .ib_code    (ib_code),
    .ib_cnf_evt (ib_cnf_evt),
    .ib_rds_evt (ib_rds_evt),
    .bus_free   (bus_free),
    .st_q       (st),
    .tmo_first  (tmo_first)
  );

  bes_ta_capture #(.AW(AW)) u_ta (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (tmo_first),
    .addr    (tmo_addr),
    .virt    (tmo_virt),
    .mode    (tmo_mode),
    .ta_q    (ta_rdata)
  );

  assign reg_rdata = st & RD_MASK;
  assign crd_irq   = st[B_CRDIE] & st[B_CRD];
endmodule

// File: rtl/bes_chk.sv
module bes_chk
  import bes_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmo_evt,
  input logic [AW-1:0] tmo_addr,
  input logic          tmo_virt,
  input logic [1:0]    tmo_mode,
  input logic [1:0]    tmo_code,
  input logic          cnf_evt,
  input logic          rds_evt,
  input logic          crd_evt,
  input logic          ib_tmo_evt,
  input logic [1:0]    ib_code,
  input logic          ib_cnf_evt,
  input logic          ib_rds_evt,
  input logic          bus_free,
  input logic          mchk_ack,
  input logic          reg_wr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic [31:0]   ta_rdata,
  input logic          crd_irq
);
  function automatic logic [31:0] ta_expect(logic [AW-1:0] a, logic v, logic [1:0] m);
    logic [31:0] r;
    r = 32'(a >> 2);
    if (v) begin
      r[TA_VIRT] = 1'b1;
      r[TA_MODE_LO +: 2] = m;
    end
    return r;
  endfunction

  logic any_evt;
  assign any_evt = tmo_evt | cnf_evt | rds_evt | crd_evt | ib_tmo_evt | ib_cnf_evt | ib_rds_evt;

  assert_rdmask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~RD_MASK) == 32'h0);

  assert_busfree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> reg_rdata[B_FREE] == $past(bus_free));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !any_evt |=> (reg_rdata & $past(reg_wdata) & W1C_MASK) == 32'h0);

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt && (!reg_rdata[B_TMO] || (reg_wr && reg_wdata[B_TMO]) || mchk_ack)
    |=> ta_rdata == ta_expect($past(tmo_addr), $past(tmo_virt), $past(tmo_mode))
        && reg_rdata[B_TMO] && reg_rdata[B_STA_LO +: 2] == $past(tmo_code));

  assert_mult_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt && reg_rdata[B_TMO] && !(reg_wr && reg_wdata[B_TMO]) && !mchk_ack
    |=> reg_rdata[B_MULT] && $stable(ta_rdata));

  assert_tahold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_evt |=> $stable(ta_rdata));

  assert_ibtmo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ib_tmo_evt && !reg_rdata[B_IBTMO] && !reg_wr
    |=> reg_rdata[B_IBTMO] && reg_rdata[B_IBSTA_LO +: 2] == $past(ib_code));

  assert_ibrds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ib_rds_evt |=> reg_rdata[B_IBRDS]);

  assert_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    crd_evt && reg_rdata[B_CRDIE] && !reg_wr |=> crd_irq);

  assert_mchk_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_ack && !tmo_evt && !cnf_evt && !ib_tmo_evt && !ib_cnf_evt
    |=> (reg_rdata & TMO_GRP) == 32'h0);

  assert_cnfwins_R14: assert property (@(posedge clk) disable iff (!rst_n)
    cnf_evt |=> reg_rdata[B_CNF]);

  assert_rdswins_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rds_evt |=> reg_rdata[B_RDS]);
endmodule

bind bus_err_capture bes_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmo_evt    (tmo_evt),
  .tmo_addr   (tmo_addr),
  .tmo_virt   (tmo_virt),
  .tmo_mode   (tmo_mode),
  .tmo_code   (tmo_code),
  .cnf_evt    (cnf_evt),
  .rds_evt    (rds_evt),
  .crd_evt    (crd_evt),
  .ib_tmo_evt (ib_tmo_evt),
  .ib_code    (ib_code),
  .ib_cnf_evt (ib_cnf_evt),
  .ib_rds_evt (ib_rds_evt),
  .bus_free   (bus_free),
  .mchk_ack   (mchk_ack),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .ta_rdata   (ta_rdata),
  .crd_irq    (crd_irq)
);

// File: tb/bus_err_capture_tb.sv
`timescale 1ns/1ps
module bus_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmo_evt = 0, tmo_virt = 0, cnf_evt = 0, rds_evt = 0, crd_evt = 0;
  logic [31:0] tmo_addr = '0;
  logic [1:0]  tmo_mode = '0, tmo_code = '0, ib_code = '0;
  logic        ib_tmo_evt = 0, ib_cnf_evt = 0, ib_rds_evt = 0, bus_free = 0, mchk_ack = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, ta_rdata;
  logic        crd_irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_err_capture u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .tmo_addr(tmo_addr),
    .tmo_virt(tmo_virt), .tmo_mode(tmo_mode), .tmo_code(tmo_code),
    .cnf_evt(cnf_evt), .rds_evt(rds_evt), .crd_evt(crd_evt),
    .ib_tmo_evt(ib_tmo_evt), .ib_code(ib_code), .ib_cnf_evt(ib_cnf_evt),
    .ib_rds_evt(ib_rds_evt), .bus_free(bus_free), .mchk_ack(mchk_ack),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ta_rdata(ta_rdata), .crd_irq(crd_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one clock with whatever strobes the caller set, then drop all strobes
  task automatic tick();
    @(negedge clk);
    tmo_evt = 0; cnf_evt = 0; rds_evt = 0; crd_evt = 0;
    ib_tmo_evt = 0; ib_cnf_evt = 0; ib_rds_evt = 0; mchk_ack = 0; reg_wr = 0;
  endtask

  task automatic wr(logic [31:0] v);
    reg_wr = 1; reg_wdata = v; tick();
  endtask

  task automatic tmo(logic [31:0] a, logic v, logic [1:0] m, logic [1:0] c);
    tmo_evt = 1; tmo_addr = a; tmo_virt = v; tmo_mode = m; tmo_code = c;
  endtask

  task automatic t_reset();
    chk("R1 status after reset", reg_rdata, 32'h0);
    chk("R1 ta after reset", ta_rdata, 32'h0);
    chk("R1 irq after reset", {31'b0, crd_irq}, 32'h0);
  endtask

  task automatic t_mask_write();
    bus_free = 1; tick();
    chk("R2 bus free bit", reg_rdata, 32'h0000_0002);
    wr(32'hFFFF_FFFF);
    chk("R3 all-ones write", reg_rdata, 32'h0000_8002);
    wr(32'h0000_0000);
    chk("R3 enable cleared", reg_rdata, 32'h0000_0002);
    bus_free = 0; tick();
    chk("R2 bus free low", reg_rdata, 32'h0);
  endtask

  task automatic t_crd_rds();
    crd_evt = 1; tick();
    chk("R12 crd sets bit14", reg_rdata, 32'h0000_4000);
    chk("R12 irq needs enable", {31'b0, crd_irq}, 32'h0);
    wr(32'h0000_8000);
    chk("R12 irq with enable", {31'b0, crd_irq}, 32'h1);
    rds_evt = 1; tick();
    chk("R12 rds sets bit13", reg_rdata, 32'h0000_E000);
    wr(32'h0000_A000);
    chk("R4 w1c bit13", reg_rdata, 32'h0000_C000);
    wr(32'h0000_C000);
    chk("R4 w1c bit14", reg_rdata, 32'h0000_8000);
    chk("R12 irq dropped", {31'b0, crd_irq}, 32'h0);
    wr(32'h0);
  endtask

  task automatic t_timeout();
    tmo(32'h2000_1234, 0, 2'b00, 2'b01); tick();
    chk("R7 first tmo status", reg_rdata, 32'h0000_1400);
    chk("R7 physical capture", ta_rdata, 32'h0800_048D);
    tmo(32'hDEAD_BEE0, 0, 2'b00, 2'b11); tick();
    chk("R9 second tmo status", reg_rdata, 32'h0000_1404);
    chk("R9 ta unchanged", ta_rdata, 32'h0800_048D);
    cnf_evt = 1; tick();
    chk("R10 first confirm", reg_rdata, 32'h0000_1504);
    wr(32'h0000_1000);
    chk("R5 bit12 group clear", reg_rdata, 32'h0);
    tmo(32'h0000_0100, 1, 2'b11, 2'b10); tick();
    chk("R8 virtual status", reg_rdata, 32'h0000_1800);
    chk("R8 virtual capture", ta_rdata, 32'hE000_0040);
    mchk_ack = 1; tick();
    chk("R13 ack clears group", reg_rdata, 32'h0);
    chk("R13 ta kept", ta_rdata, 32'hE000_0040);
  endtask

  task automatic t_confirm();
    cnf_evt = 1; tick();
    chk("R10 confirm set", reg_rdata, 32'h0000_0100);
    cnf_evt = 1; tick();
    chk("R10 confirm again", reg_rdata, 32'h0000_0104);
    mchk_ack = 1; tick();
    chk("R13 clears confirm", reg_rdata, 32'h0);
  endtask

  task automatic t_ibuf();
    ib_tmo_evt = 1; ib_code = 2'b10; tick();
    chk("R11 ib tmo first", reg_rdata, 32'h0000_0060);
    ib_tmo_evt = 1; ib_code = 2'b01; tick();
    chk("R11 ib tmo again", reg_rdata, 32'h0000_0064);
    ib_cnf_evt = 1; tick();
    chk("R11 ib confirm", reg_rdata, 32'h0000_006C);
    ib_rds_evt = 1; tick();
    chk("R11 ib rds", reg_rdata, 32'h0000_00EC);
    wr(32'h0000_0040);
    chk("R6 bit6 group clear", reg_rdata, 32'h0000_00A4);
    wr(32'h0000_0080);
    chk("R4 w1c bit7", reg_rdata, 32'h0000_0024);
    wr(32'h0000_1000);
    chk("R5 clears mult", reg_rdata, 32'h0000_0020);
  endtask

  task automatic t_collide();
    tmo(32'h0000_0010, 0, 2'b00, 2'b01); tick();
    chk("R7 capture before collision", ta_rdata, 32'h0000_0004);
    tmo(32'h0000_0080, 0, 2'b00, 2'b10); reg_wr = 1; reg_wdata = 32'h0000_1000; tick();
    chk("R14 write+tmo status", reg_rdata, 32'h0000_1820);
    chk("R14 write+tmo fresh capture", ta_rdata, 32'h0000_0020);
    cnf_evt = 1; tick();
    chk("R10 confirm in collision set", reg_rdata, 32'h0000_1920);
    cnf_evt = 1; mchk_ack = 1; tick();
    chk("R14 ack+confirm", reg_rdata, 32'h0000_0120);
    rds_evt = 1; tick();
    rds_evt = 1; reg_wr = 1; reg_wdata = 32'h0000_2000; tick();
    chk("R14 write+rds", reg_rdata, 32'h0000_2120);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_mask_write();
    t_crd_rds();
    t_timeout();
    t_confirm();
    t_ibuf();
    t_collide();
    rst_n = 0; tick(); tick();
    t_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule